// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes an incoming frame as a byte stream, one byte per beat, with start-of-frame, end-of-frame and error marks. It stores each frame in a buffer that a host has prepared. A small internal table holds the descriptors. Each descriptor has a status word, a length word and a buffer base address. The engine steps through the table as a ring.

A descriptor belongs to the engine only while its empty flag is set. When a frame ends, the engine writes back the byte count and the error flags and clears the empty flag, which hands the descriptor back to the host. A wrap flag marks the last descriptor in the ring. If the engine meets a descriptor that the host still owns, it stalls and drops frames. It stays stalled until the host writes a poll word.

Buffer memory is reached through a plain registered write port, one byte per cycle. The host reaches the descriptor table through a word port with a combinational read.

Top module: `rxd_ring_engine`

## Requirements
- R1: A frame is stored only when the current descriptor has its empty flag (status bit 15) set at the start-of-frame beat. Byte k of the frame is written to buffer address base+k, in arrival order, one registered write per accepted byte.
- R2: At the end-of-frame beat the engine updates the current descriptor:
  - it clears the empty flag;
  - it keeps the wrap flag (status bit 13) and every other non-error status bit;
  - it sets the length word to the number of bytes stored, which includes the 4 trailing check-sequence bytes present in the stream.
- R3: Status bits [5:0] are error flags and are all zero for a good frame. Bit 0 is set when rx_err was high on any beat of the frame. Bit 1 is the too-long flag.
- R4: After a frame completes, the next descriptor is index 0 if the completed descriptor had its wrap flag set. Otherwise it is the next index, and after the last table entry it returns to 0.
- R5: A start-of-frame that meets a non-empty current descriptor puts the engine in a stalled state. While stalled, every frame is dropped: there are no buffer writes and no descriptor change. This holds even after the host sets the empty flag again.
- R6: A poll write ends the stall. A poll write is poll_we with poll_wdata bit 24 set. A poll write with bit 24 clear has no effect.
- R7: A frame longer than MAX_FRAME (1518) bytes keeps only its first MAX_FRAME bytes, reports length MAX_FRAME and sets error bit 1. A frame of exactly MAX_FRAME bytes is not flagged.
- R8: Reset sets the ring index to 0, clears every descriptor word to zero and issues no buffer write.
- R9: The host address is split into two parts:
  - bits [1:0] select the field: 0 status, 1 length, 2 buffer base, 3 reads zero;
  - the upper bits select the descriptor.
  Writes land on the next clock edge. host_rdata follows host_addr without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A stream byte is present this cycle |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_err | input | 1 | Receive error seen on this beat |
| rx_data | input | 8 | Stream byte |
| host_we | input | 1 | Host descriptor write strobe |
| host_addr | input | IDX_W+2 | Descriptor index and field select |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Selected descriptor word |
| poll_we | input | 1 | Poll register write strobe |
| poll_wdata | input | 32 | Poll register write word; bit 24 requests a re-poll |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_data | output | 8 | Buffer byte |

## Verification
The hardest state to reach is the stall that outlives a re-armed descriptor. To get there, the bench fills every descriptor of a four-entry ring. The next frame, after the wrap, then meets a descriptor the host has not returned. The bench then sets that descriptor's empty flag again and sends another frame, to show that the engine still drops it. A poll word without bit 24 follows and must not release the stall. Only the real poll word lets a frame land, and it lands in descriptor 0, which also confirms the wrap. Truncation is reached with a 1530-byte frame and compared with a frame of exactly 1518 bytes.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;
   localparam int DW         = 16;  // descriptor word width
   localparam int ST_EMPTY   = 15;  // engine owns descriptor
   localparam int ST_WRAP    = 13;  // last descriptor of ring
   localparam int ERR_W      = 6;   // error field in status[5:0]
   localparam int ERR_RX     = 0;
   localparam int ERR_LONG   = 1;

   typedef enum logic [1:0] {
      FLD_STATUS = 2'd0,
      FLD_LENGTH = 2'd1,
      FLD_BASE   = 2'd2,
      FLD_NONE   = 2'd3
   } fld_e;
endpackage

// File: rtl/rxd_desc_mem.sv
`timescale 1ns/1ps
module rxd_desc_mem #(
   parameter int NDESC = 8,
   parameter int IDX_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_we,
   input  logic [IDX_W-1:0]      host_idx,
   input  rxd_pkg::fld_e         host_fld,
   input  logic [rxd_pkg::DW-1:0] host_wdata,
   output logic [rxd_pkg::DW-1:0] host_rdata,
   input  logic [IDX_W-1:0]      cur_idx,
   output logic                  cur_empty,
   output logic                  cur_wrap,
   output logic [rxd_pkg::DW-1:0] cur_base,
   input  logic                  upd_en,
   input  logic [IDX_W-1:0]      upd_idx,
   input  logic [rxd_pkg::ERR_W-1:0] upd_err,
   input  logic [rxd_pkg::DW-1:0] upd_len
);
   import rxd_pkg::*;

   localparam logic [DW-1:0] CLR_MASK = ~((DW'(1) << ST_EMPTY) | DW'({ERR_W{1'b1}}));

   logic [DW-1:0] stat_q [NDESC];
   logic [DW-1:0] len_q  [NDESC];
   logic [DW-1:0] base_q [NDESC];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int d = 0; d < NDESC; d++) begin
            stat_q[d] <= '0;
            len_q[d]  <= '0;
            base_q[d] <= '0;
         end
      end else begin
         for (int d = 0; d < NDESC; d++) begin
            if (upd_en && upd_idx == IDX_W'(d)) begin
               stat_q[d] <= (stat_q[d] & CLR_MASK) | DW'(upd_err);
               len_q[d]  <= upd_len;
            end else if (host_we && host_idx == IDX_W'(d)) begin
               case (host_fld)
                  FLD_STATUS: stat_q[d] <= host_wdata;
                  FLD_LENGTH: len_q[d]  <= host_wdata;
                  FLD_BASE:   base_q[d] <= host_wdata;
                  default:    ;
               endcase
            end
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      if (32'(host_idx) < NDESC) begin
         case (host_fld)
            FLD_STATUS: host_rdata = stat_q[host_idx];
            FLD_LENGTH: host_rdata = len_q[host_idx];
            FLD_BASE:   host_rdata = base_q[host_idx];
            default:    host_rdata = '0;
         endcase
      end
   end

   assign cur_empty = stat_q[cur_idx][ST_EMPTY];
   assign cur_wrap  = stat_q[cur_idx][ST_WRAP];
   assign cur_base  = base_q[cur_idx];

   // R1
   upd_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |-> stat_q[upd_idx][ST_EMPTY]);
   // R2
   upd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> !stat_q[$past(upd_idx)][ST_EMPTY]);
endmodule

// File: rtl/rxd_ring_ctrl.sv
`timescale 1ns/1ps
module rxd_ring_ctrl #(
   parameter int NDESC = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_sof,
   input  logic             rx_eof,
   input  logic             cur_empty,
   input  logic             cur_wrap,
   input  logic             poll,
   output logic [IDX_W-1:0] cur_idx,
   output logic             start_ok,
   output logic             beat_on,
   output logic             finish
);
   logic             in_frame_q, stalled_q, stall_hit;
   logic [IDX_W-1:0] idx_q, idx_inc;

   assign start_ok  = rx_valid & rx_sof & ~in_frame_q & ~stalled_q & cur_empty;
   assign stall_hit = rx_valid & rx_sof & ~in_frame_q & ~stalled_q & ~cur_empty;
   assign beat_on   = rx_valid & (in_frame_q | start_ok);
   assign finish    = beat_on & rx_eof;
   assign cur_idx   = idx_q;

   generate
      if ((1 << IDX_W) == NDESC) begin : g_pow2
         assign idx_inc = idx_q + 1'b1;
      end else begin : g_cmp
         assign idx_inc = (idx_q == IDX_W'(NDESC - 1)) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         stalled_q  <= 1'b0;
         idx_q      <= '0;
      end else begin
         if (finish)        in_frame_q <= 1'b0;
         else if (start_ok) in_frame_q <= 1'b1;
         if (poll)           stalled_q <= 1'b0;
         else if (stall_hit) stalled_q <= 1'b1;
         if (finish) idx_q <= cur_wrap ? '0 : idx_inc;
      end
   end

   // R4
   wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && cur_wrap) |=> (cur_idx == '0));
   // R4
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cur_idx) < NDESC);
   // R6
   poll_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll |=> !stalled_q);
endmodule

// File: rtl/rxd_byte_path.sv
`timescale 1ns/1ps
module rxd_byte_path #(
   parameter int ADDR_W    = 16,
   parameter int LEN_W     = 11,
   parameter int MAX_FRAME = 1518
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_ok,
   input  logic                      beat_on,
   input  logic [7:0]                rx_data,
   input  logic                      rx_err,
   input  logic [ADDR_W-1:0]         base,
   output logic                      buf_we,
   output logic [ADDR_W-1:0]         buf_addr,
   output logic [7:0]                buf_data,
   output logic [rxd_pkg::DW-1:0]    done_len,
   output logic [rxd_pkg::ERR_W-1:0] done_err
);
   import rxd_pkg::*;

   logic [LEN_W-1:0] count_q, offset, cnt_nxt;
   logic             long_q, err_q, long_nxt, err_nxt, room;

   assign offset   = start_ok ? '0 : count_q;
   assign room     = offset < LEN_W'(MAX_FRAME);
   assign cnt_nxt  = room ? offset + 1'b1 : offset;
   assign long_nxt = (~start_ok & long_q) | (beat_on & ~room);
   assign err_nxt  = (~start_ok & err_q) | (beat_on & rx_err);

   always_comb begin
      done_err           = '0;
      done_err[ERR_RX]   = err_nxt;
      done_err[ERR_LONG] = long_nxt;
   end
   assign done_len = DW'(cnt_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         long_q   <= 1'b0;
         err_q    <= 1'b0;
         buf_we   <= 1'b0;
         buf_addr <= '0;
         buf_data <= '0;
      end else begin
         buf_we <= beat_on & room;
         if (beat_on) begin
            count_q  <= cnt_nxt;
            long_q   <= long_nxt;
            err_q    <= err_nxt;
            buf_addr <= base + ADDR_W'(offset);
            buf_data <= rx_data;
         end
      end
   end

   // R7
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(count_q) <= MAX_FRAME);
endmodule

// File: rtl/rxd_ring_engine.sv
`timescale 1ns/1ps
module rxd_ring_engine #(
   parameter int NDESC     = 8,
   parameter int ADDR_W    = 16,
   parameter int MAX_FRAME = 1518,
   parameter int BUF_BYTES = 1520,
   parameter int POLL_BIT  = 24,
   localparam int IDX_W    = $clog2(NDESC),
   localparam int HA_W     = IDX_W + 2,
   localparam int LEN_W    = $clog2(MAX_FRAME + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic              rx_err,
   input  logic [7:0]        rx_data,
   input  logic              host_we,
   input  logic [HA_W-1:0]   host_addr,
   input  logic [15:0]       host_wdata,
   output logic [15:0]       host_rdata,
   input  logic              poll_we,
   input  logic [31:0]       poll_wdata,
   output logic              buf_we,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [7:0]        buf_data
);
   import rxd_pkg::*;

   generate
      if (NDESC < 2) begin : g_bad_ndesc
         $error("NDESC must be at least 2");
      end
      if (MAX_FRAME > BUF_BYTES) begin : g_bad_frame
         $error("MAX_FRAME must fit in BUF_BYTES");
      end
      if (ADDR_W > DW) begin : g_bad_addr
         $error("ADDR_W must fit in a descriptor word");
      end
      if (POLL_BIT > 31) begin : g_bad_poll
         $error("POLL_BIT must lie in the poll word");
      end
   endgenerate

   logic             poll, cur_empty, cur_wrap, start_ok, beat_on, finish;
   logic [IDX_W-1:0] cur_idx;
   logic [DW-1:0]    cur_base, done_len;
   logic [ERR_W-1:0] done_err;

   assign poll = poll_we & poll_wdata[POLL_BIT];

   rxd_ring_ctrl #(.NDESC(NDESC), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .cur_empty(cur_empty), .cur_wrap(cur_wrap),
      .poll(poll), .cur_idx(cur_idx), .start_ok(start_ok),
      .beat_on(beat_on), .finish(finish)
   );

   rxd_byte_path #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_path (
      .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .beat_on(beat_on),
      .rx_data(rx_data), .rx_err(rx_err), .base(cur_base[ADDR_W-1:0]),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .done_len(done_len), .done_err(done_err)
   );

   rxd_desc_mem #(.NDESC(NDESC), .IDX_W(IDX_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .host_we(host_we),
      .host_idx(host_addr[HA_W-1:2]), .host_fld(fld_e'(host_addr[1:0])),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cur_idx(cur_idx), .cur_empty(cur_empty), .cur_wrap(cur_wrap),
      .cur_base(cur_base), .upd_en(finish), .upd_idx(cur_idx),
      .upd_err(done_err), .upd_len(done_len)
   );
endmodule

// File: tb/rxd_ring_engine_bench.sv
`timescale 1ns/1ps
module rxd_ring_engine_bench;
   localparam int NDESC = 8;
   localparam int HA_W  = $clog2(NDESC) + 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
   logic [7:0] rx_data = 0;
   logic host_we = 0;
   logic [HA_W-1:0] host_addr = 0;
   logic [15:0] host_wdata = 0, host_rdata;
   logic poll_we = 0;
   logic [31:0] poll_wdata = 0;
   logic buf_we;
   logic [15:0] buf_addr;
   logic [7:0] buf_data;

   int checks = 0, errors = 0, wr_count = 0;
   logic [7:0] bmem [65536];

   always #2.5 clk = ~clk;

   rxd_ring_engine u_rxd_ring_engine (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .rx_err(rx_err), .rx_data(rx_data),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .poll_we(poll_we), .poll_wdata(poll_wdata),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data)
   );

   always @(posedge clk) begin
      if (buf_we) begin
         bmem[buf_addr] <= buf_data;
         wr_count <= wr_count + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hwr(input int idx, input int fld, input logic [15:0] v);
      @(negedge clk);
      host_we = 1; host_addr = HA_W'((idx << 2) | fld); host_wdata = v;
      @(negedge clk);
      host_we = 0;
   endtask

   task automatic hrd(input int idx, input int fld, output logic [15:0] v);
      @(negedge clk);
      host_addr = HA_W'((idx << 2) | fld);
      #1 v = host_rdata;
   endtask

   task automatic do_poll(input logic [31:0] v);
      @(negedge clk);
      poll_we = 1; poll_wdata = v;
      @(negedge clk);
      poll_we = 0;
   endtask

   task automatic send_frame(input int n, input logic [7:0] seed, input int err_at);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1);
         rx_err = (i == err_at); rx_data = seed + 8'(i);
      end
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic chk_buf(input string req, input int base, input int n, input logic [7:0] seed);
      int bad = 0;
      for (int i = 0; i < n; i++)
         if (bmem[base + i] !== seed + 8'(i)) bad++;
      chk(req, bad, 0);
   endtask

   task automatic arm_ring();
      for (int i = 0; i < 4; i++) begin
         hwr(i, 2, 16'(16'h1000 * (i + 1)));
         hwr(i, 0, (i == 3) ? 16'hA000 : 16'h8000);
      end
   endtask

   task automatic t_reset();
      logic [15:0] v;
      chk("R8 no buffer write after reset", buf_we, 0);
      hrd(0, 0, v); chk("R8 status zero", v, 0);
      hrd(5, 2, v); chk("R8 base zero", v, 0);
   endtask

   task automatic t_host();
      logic [15:0] v;
      arm_ring();
      hrd(3, 0, v); chk("R9 status readback", v, 16'hA000);
      hrd(2, 2, v); chk("R9 base readback", v, 16'h3000);
      hrd(2, 3, v); chk("R9 unused field reads zero", v, 0);
   endtask

   task automatic t_good();
      logic [15:0] v; int w0 = wr_count;
      send_frame(64, 8'h10, -1);
      hrd(0, 0, v); chk("R2 R3 good status", v, 16'h0000);
      hrd(0, 1, v); chk("R2 length with check bytes", v, 64);
      chk_buf("R1 buffer contents", 16'h1000, 64, 8'h10);
      chk("R1 write count", wr_count - w0, 64);
   endtask

   task automatic t_err();
      logic [15:0] v;
      send_frame(100, 8'h33, 50);
      hrd(1, 0, v); chk("R3 rx error flag", v, 16'h0001);
      hrd(1, 1, v); chk("R3 length on error", v, 100);
   endtask

   task automatic t_short_and_wrap();
      logic [15:0] v;
      send_frame(1, 8'h5A, -1);
      hrd(2, 1, v); chk("R2 single byte length", v, 1);
      send_frame(70, 8'h80, -1);
      hrd(3, 0, v); chk("R2 wrap flag kept", v, 16'h2000);
      hrd(3, 1, v); chk("R2 length desc3", v, 70);
   endtask

   task automatic t_stall();
      logic [15:0] v; int w0;
      w0 = wr_count;
      send_frame(40, 8'h01, -1);
      chk("R5 dropped: no writes", wr_count - w0, 0);
      hrd(0, 1, v); chk("R5 dropped: desc0 untouched", v, 64);
      hwr(0, 0, 16'h8000);
      w0 = wr_count;
      send_frame(40, 8'h02, -1);
      chk("R5 stall holds after rearm", wr_count - w0, 0);
      hrd(0, 0, v); chk("R5 desc0 still empty", v, 16'h8000);
      do_poll(32'h0000_0001);
      w0 = wr_count;
      send_frame(40, 8'h03, -1);
      chk("R6 poll without bit 24 ignored", wr_count - w0, 0);
      do_poll(32'h0100_0000);
      send_frame(80, 8'hC0, -1);
      hrd(0, 0, v); chk("R4 R6 frame in desc0 after wrap", v, 16'h0000);
      hrd(0, 1, v); chk("R4 desc0 length", v, 80);
      chk_buf("R4 desc0 buffer", 16'h1000, 80, 8'hC0);
   endtask

   task automatic t_long();
      logic [15:0] v; int w0;
      hwr(1, 0, 16'h8000);
      w0 = wr_count;
      send_frame(1530, 8'h07, -1);
      hrd(1, 0, v); chk("R7 too-long flag", v, 16'h0002);
      hrd(1, 1, v); chk("R7 truncated length", v, 1518);
      chk("R7 writes capped", wr_count - w0, 1518);
      chk_buf("R7 stored prefix", 16'h2000, 1518, 8'h07);
      hwr(2, 0, 16'h8000);
      send_frame(1518, 8'h44, -1);
      hrd(2, 0, v); chk("R7 exact max not flagged", v, 16'h0000);
      hrd(2, 1, v); chk("R7 exact max length", v, 1518);
   endtask

   task automatic t_reset_mid();
      logic [15:0] v;
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk); rst_n = 1;
      hrd(1, 1, v); chk("R8 reset clears length", v, 0);
      arm_ring();
      send_frame(20, 8'h90, -1);
      hrd(0, 1, v); chk("R8 index back to 0", v, 20);
      hrd(3, 0, v); chk("R8 desc3 untouched", v, 16'hA000);
   endtask

   initial begin
      for (int i = 0; i < 65536; i++) bmem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_host();
      t_good();
      t_err();
      t_short_and_wrap();
      t_stall();
      t_long();
      t_reset_mid();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule